// File: doc/BRIEF.md
# Single-Precision Result Rounder with Exception Flags

This block is the last stage of a floating-point pipeline. An arithmetic datapath hands it an unrounded intermediate result. The result arrives as a sign, an unbiased two's-complement exponent and a normalized significand. The significand holds a hidden one, 23 fraction bits and two extra bits below the fraction, and a separate sticky bit summarizes everything further down. The block rounds this value once and produces the packed single-precision word. In the same cycle it produces the exception flags. A fused multiply-accumulate therefore passes through the block a single time. Add and multiply each pass through it once per result.

A two-bit mode input selects the rounding direction. The selected mode also decides what an out-of-range magnitude becomes. After rounding, every result is sorted into one of five result classes:
- `CLS_ZERO`: signed zero.
- `CLS_FINITE`: a normal number.
- `CLS_INF`: signed infinity.
- `CLS_MAXF`: the largest finite magnitude.
- `CLS_NAN`: the default quiet NaN.

The class selects how the output word is assembled. Class selection has these transitions:
- the invalid input leads to `CLS_NAN`;
- a zero significand leads to `CLS_ZERO`;
- too large a magnitude leads to `CLS_INF` or `CLS_MAXF`, depending on the mode;
- too small a magnitude leads to `CLS_ZERO` with underflow;
- anything else leads to `CLS_FINITE`.

The word and the flags leave through one register stage, together with a valid bit.

Top module: `rnd_unit`

## Requirements
- R1: The mode `rm` is decoded as follows: 2'b01 rounds toward zero, and 2'b00, 2'b10 and 2'b11 all round to nearest-even.
- R2: Bit layout and round-to-nearest:
  - `in_sig[25]` is the hidden one, `in_sig[24:2]` is the fraction, `in_sig[1]` is the guard bit and `in_sig[0]` is the round bit. `in_sticky` ORs all lower bits.
  - In nearest mode the 24-bit kept significand increments when the discarded part exceeds half an LSB.
  - On an exact half it increments only when the kept LSB is 1.
- R3: In toward-zero mode the discarded bits are dropped and the kept significand is never incremented.
- R4: If the increment carries out of the 24-bit significand, the fraction becomes 0 and the exponent rises by one. All range checks use this adjusted exponent.
- R5: In nearest mode, a rounded biased exponent (exponent + 127) of 255 or more gives a signed infinity: exponent field 255 and fraction 0. It also raises overflow and inexact.
- R6: In toward-zero mode, the same condition gives the signed largest finite value: exponent field 254 and fraction all ones. It also raises overflow and inexact.
- R7: A rounded biased exponent of 0 or less gives a signed zero and raises underflow and inexact.
- R8: Inexact is raised exactly when guard, round or sticky is nonzero for a normal result, or when overflow or underflow is raised.
- R9: A significand whose hidden bit is 0 gives a signed zero with all of overflow, underflow and inexact clear.
- R10: When `in_inv` is set, the word is 0x7FC00000 and `out_inv` is set. Overflow, underflow and inexact are clear.
- R11: `out_dz` repeats `in_dz`, and the divide-by-zero input does not change the word.
- R12: `out_err` is set exactly when `in_den` is 1 and `dn_mode` is 0.
- R13: Output timing:
  - Every output is registered and appears one clock after the accepted input, with `out_valid` equal to the previous `in_valid`.
  - While `out_valid` is 0, and in reset, the word and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Intermediate result present |
| rm | input | 2 | Rounding mode |
| in_sign | input | 1 | Sign of the intermediate |
| in_exp | input | 10 | Unbiased exponent, two's complement |
| in_sig | input | 26 | Hidden bit, fraction, guard and round bits |
| in_sticky | input | 1 | OR of all bits below the round bit |
| in_inv | input | 1 | Upstream invalid-operation flag |
| in_dz | input | 1 | Upstream divide-by-zero flag |
| in_den | input | 1 | An operand was denormalized |
| dn_mode | input | 1 | 1 = denormals handled as zero, no error |
| out_valid | output | 1 | Result valid |
| out_word | output | 32 | Packed single-precision result |
| out_inv | output | 1 | Invalid-operation flag |
| out_dz | output | 1 | Divide-by-zero flag |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inx | output | 1 | Inexact flag |
| out_err | output | 1 | Denormal-operand error flag |

## Verification
The bench sweeps every combination of the following:
- all four modes;
- all eight guard/round/sticky patterns;
- both kept LSB values;
- three fraction patterns;
- exponents placed around both ends of the range.

These inputs cover the following corner cases and the faults each one exposes:
- Exact ties: a design that rounds ties away from zero gives an odd LSB.
- An all-ones fraction that carries: a design that skips renormalization puts out a fraction of zero without raising the exponent. If the range check uses the old exponent, 2^127·(2−2^−24) comes out finite, or a value just below 2^−126 is wrongly flushed.
- Overflow in toward-zero mode: a design that does not clamp returns infinity.
- The reserved modes: a design that decodes them as truncation rounds them down.
- Invalid, zero and denormal-gating inputs: a design that gates wrongly leaks overflow or underflow alongside the NaN, or raises the error flag when `dn_mode` is set.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    // Result classes chosen after rounding; each selects one packing rule.
    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_FINITE = 3'd1,
        CLS_INF    = 3'd2,
        CLS_MAXF   = 3'd3,
        CLS_NAN    = 3'd4
    } res_class_e;

    localparam logic [1:0] RM_NEAREST = 2'b00;
    localparam logic [1:0] RM_TOZERO  = 2'b01;

endpackage

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int MAN_W  = 23,
    parameter int XTRA_W = 2
) (
    input  logic [MAN_W+XTRA_W:0] sig,
    input  logic                  sticky,
    input  logic                  rtz,
    output logic [MAN_W-1:0]      frac,
    output logic                  carry,
    output logic                  lost
);
    localparam int KEEP_W = MAN_W + 1;

    logic [KEEP_W-1:0] kept;
    logic              guard;
    logic              rest;
    logic              inc;
    logic [KEEP_W:0]   sum;

    assign kept  = sig[MAN_W+XTRA_W:XTRA_W];
    assign guard = sig[XTRA_W-1];

    generate
        if (XTRA_W > 1) begin : g_multi
            assign rest = (|sig[XTRA_W-2:0]) | sticky;
        end else begin : g_single
            assign rest = sticky;
        end
    endgenerate

    // nearest-even: above half, or exactly half with odd LSB
    assign inc   = !rtz && guard && (rest || kept[0]);
    assign sum   = {1'b0, kept} + {{KEEP_W{1'b0}}, inc};
    assign carry = sum[KEEP_W];
    // on carry-out the significand is 10.00..0; shift right by one
    assign frac  = carry ? sum[MAN_W:1] : sum[MAN_W-1:0];
    assign lost  = guard | rest;

endmodule

// File: rtl/rnd_range.sv
module rnd_range
    import rnd_pkg::*;
#(
    parameter int EXP_W    = 8,
    parameter int EXP_IN_W = 10
) (
    input  logic [EXP_IN_W-1:0] exp_in,
    input  logic                carry,
    input  logic                is_zero,
    input  logic                inv,
    input  logic                rtz,
    output res_class_e          cls,
    output logic [EXP_W-1:0]    bexp,
    output logic                ovf,
    output logic                unf
);
    localparam int BW   = EXP_IN_W + 2;
    localparam int BIAS = (2 ** (EXP_W - 1)) - 1;
    localparam int TOPV = (2 ** EXP_W) - 1;

    logic [BW-1:0] be;
    logic          neg;
    logic          big;
    logic          tiny;

    assign be   = {{2{exp_in[EXP_IN_W-1]}}, exp_in} + BW'(BIAS) + BW'(carry);
    assign neg  = be[BW-1];
    assign big  = !neg && (be >= BW'(TOPV));
    assign tiny = neg || (be == '0);
    assign bexp = be[EXP_W-1:0];

    always_comb begin
        cls = CLS_FINITE;
        ovf = 1'b0;
        unf = 1'b0;
        if (inv) begin
            cls = CLS_NAN;
        end else if (is_zero) begin
            cls = CLS_ZERO;
        end else if (big) begin
            ovf = 1'b1;
            cls = rtz ? CLS_MAXF : CLS_INF;
        end else if (tiny) begin
            unf = 1'b1;
            cls = CLS_ZERO;
        end
    end

endmodule

// File: rtl/rnd_outreg.sv
module rnd_outreg
    import rnd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  res_class_e             cls,
    input  logic                   sign,
    input  logic [EXP_W-1:0]       bexp,
    input  logic [MAN_W-1:0]       frac,
    input  logic                   ovf,
    input  logic                   unf,
    input  logic                   lost,
    input  logic                   inv,
    input  logic                   dz,
    input  logic                   err,
    output logic                   out_valid,
    output logic [EXP_W+MAN_W:0]   out_word,
    output logic                   out_inv,
    output logic                   out_dz,
    output logic                   out_ovf,
    output logic                   out_unf,
    output logic                   out_inx,
    output logic                   out_err
);
    localparam int WORD_W = EXP_W + MAN_W + 1;

    logic [WORD_W-1:0] word_d;
    logic              inx_d;

    always_comb begin
        unique case (cls)
            CLS_ZERO:   word_d = {sign, {(WORD_W-1){1'b0}}};
            CLS_FINITE: word_d = {sign, bexp, frac};
            CLS_INF:    word_d = {sign, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
            CLS_MAXF:   word_d = {sign, {(EXP_W-1){1'b1}}, 1'b0, {MAN_W{1'b1}}};
            CLS_NAN:    word_d = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
            default:    word_d = '0;
        endcase
        inx_d = ovf | unf | (lost && (cls == CLS_FINITE));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_inv   <= 1'b0;
            out_dz    <= 1'b0;
            out_ovf   <= 1'b0;
            out_unf   <= 1'b0;
            out_inx   <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_word  <= in_valid ? word_d : '0;
            out_inv   <= in_valid & inv;
            out_dz    <= in_valid & dz;
            out_ovf   <= in_valid & ovf;
            out_unf   <= in_valid & unf;
            out_inx   <= in_valid & inx_d;
            out_err   <= in_valid & err;
        end
    end

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
    import rnd_pkg::*;
#(
    parameter int EXP_W    = 8,
    parameter int MAN_W    = 23,
    parameter int XTRA_W   = 2,
    parameter int EXP_IN_W = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [1:0]                rm,
    input  logic                      in_sign,
    input  logic [EXP_IN_W-1:0]       in_exp,
    input  logic [MAN_W+XTRA_W:0]     in_sig,
    input  logic                      in_sticky,
    input  logic                      in_inv,
    input  logic                      in_dz,
    input  logic                      in_den,
    input  logic                      dn_mode,
    output logic                      out_valid,
    output logic [EXP_W+MAN_W:0]      out_word,
    output logic                      out_inv,
    output logic                      out_dz,
    output logic                      out_ovf,
    output logic                      out_unf,
    output logic                      out_inx,
    output logic                      out_err
);
    localparam int SIG_W = MAN_W + XTRA_W + 1;

    logic             rtz;
    logic             is_zero;
    logic [MAN_W-1:0] frac;
    logic             carry;
    logic             lost;
    res_class_e       cls;
    logic [EXP_W-1:0] bexp;
    logic             ovf;
    logic             unf;
    logic             err;

    // reserved encodings fall back to nearest
    assign rtz     = (rm == RM_TOZERO);
    assign is_zero = !in_sig[SIG_W-1];
    assign err     = in_den & ~dn_mode;

    rnd_incr #(.MAN_W(MAN_W), .XTRA_W(XTRA_W)) u_incr (
        .sig    (in_sig),
        .sticky (in_sticky),
        .rtz    (rtz),
        .frac   (frac),
        .carry  (carry),
        .lost   (lost)
    );

    rnd_range #(.EXP_W(EXP_W), .EXP_IN_W(EXP_IN_W)) u_range (
        .exp_in  (in_exp),
        .carry   (carry),
        .is_zero (is_zero),
        .inv     (in_inv),
        .rtz     (rtz),
        .cls     (cls),
        .bexp    (bexp),
        .ovf     (ovf),
        .unf     (unf)
    );

    rnd_outreg #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .cls       (cls),
        .sign      (in_sign),
        .bexp      (bexp),
        .frac      (frac),
        .ovf       (ovf),
        .unf       (unf),
        .lost      (lost),
        .inv       (in_inv),
        .dz        (in_dz),
        .err       (err),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_inv   (out_inv),
        .out_dz    (out_dz),
        .out_ovf   (out_ovf),
        .out_unf   (out_unf),
        .out_inx   (out_inx),
        .out_err   (out_err)
    );

endmodule

// File: rtl/rnd_unit_chk.sv
module rnd_unit_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [1:0]           rm,
    input logic                 in_inv,
    input logic                 in_dz,
    input logic                 in_den,
    input logic                 dn_mode,
    input logic                 out_valid,
    input logic [EXP_W+MAN_W:0] out_word,
    input logic                 out_inv,
    input logic                 out_dz,
    input logic                 out_ovf,
    input logic                 out_unf,
    input logic                 out_inx,
    input logic                 out_err
);
    localparam logic [EXP_W+MAN_W:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    assert_valid_lat_R13: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_word == '0) && !out_inv && !out_dz && !out_ovf
                       && !out_unf && !out_inx && !out_err);

    assert_nan_force_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_inv) |-> (out_word == QNAN) && out_inv
                                      && !out_ovf && !out_unf && !out_inx);

    assert_rtz_no_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && (rm == 2'b01) && !in_inv)
            |-> out_word[EXP_W+MAN_W-1:MAN_W] != {EXP_W{1'b1}});

    assert_range_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ovf || out_unf) |-> out_inx);

    assert_unf_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_unf |-> (out_word[EXP_W+MAN_W-1:0] == '0));

    assert_err_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_err == $past(in_valid && in_den && !dn_mode));

    assert_dz_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_dz == $past(in_valid && in_dz));

endmodule

bind rnd_unit rnd_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .rm        (rm),
    .in_inv    (in_inv),
    .in_dz     (in_dz),
    .in_den    (in_den),
    .dn_mode   (dn_mode),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_inv   (out_inv),
    .out_dz    (out_dz),
    .out_ovf   (out_ovf),
    .out_unf   (out_unf),
    .out_inx   (out_inx),
    .out_err   (out_err)
);

// File: tb/rnd_unit_bench.sv
module rnd_unit_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  rm = 2'b00;
    logic        in_sign = 1'b0;
    logic [9:0]  in_exp = '0;
    logic [25:0] in_sig = '0;
    logic        in_sticky = 1'b0;
    logic        in_inv = 1'b0;
    logic        in_dz = 1'b0;
    logic        in_den = 1'b0;
    logic        dn_mode = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_inv, out_dz, out_ovf, out_unf, out_inx, out_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    rnd_unit u_rnd_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rm(rm),
        .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
        .in_sticky(in_sticky), .in_inv(in_inv), .in_dz(in_dz),
        .in_den(in_den), .dn_mode(dn_mode), .out_valid(out_valid),
        .out_word(out_word), .out_inv(out_inv), .out_dz(out_dz),
        .out_ovf(out_ovf), .out_unf(out_unf), .out_inx(out_inx),
        .out_err(out_err)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] flagvec();
        return {26'd0, out_valid, out_inv, out_dz, out_ovf, out_unf, out_inx}
               | {25'd0, out_err, 6'd0};
    endfunction

    // drive one input, wait for the register, sample after the edge
    task automatic apply(input logic [1:0] m, input logic s, input int e,
                         input logic [25:0] sg, input logic st,
                         input logic inv, input logic dz,
                         input logic den, input logic dnm);
        @(negedge clk);
        in_valid = 1'b1; rm = m; in_sign = s; in_exp = e[9:0];
        in_sig = sg; in_sticky = st; in_inv = inv; in_dz = dz;
        in_den = den; dn_mode = dnm;
        @(posedge clk);
        #1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // arithmetic model of rounding and range handling
    task automatic model(input int mode, input logic s, input int e,
                         input logic [25:0] sg, input logic st,
                         output logic [31:0] w, output logic ovf,
                         output logic unf, output logic inx,
                         output bit carried);
        longint kept, rem, sum;
        int be;
        bit near;
        near = (mode != 1);
        kept = longint'(sg[25:2]);
        rem = longint'({sg[1:0], st});
        sum = kept + ((near && (rem > 4 || (rem == 4 && kept[0]))) ? 1 : 0);
        carried = 0;
        be = e + 127;
        if (sum == (longint'(1) << 24)) begin
            sum = longint'(1) << 23;
            be = be + 1;
            carried = 1;
        end
        ovf = 0; unf = 0;
        if (!sg[25]) begin
            w = {s, 31'd0};
        end else if (be >= 255) begin
            ovf = 1;
            w = near ? {s, 8'hFF, 23'd0} : {s, 8'hFE, 23'h7FFFFF};
        end else if (be <= 0) begin
            unf = 1;
            w = {s, 31'd0};
        end else begin
            w = {s, be[7:0], sum[22:0]};
        end
        inx = ovf | unf | (sg[25] && rem != 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int exps[7] = '{-150, -127, -126, -1, 0, 127, 128};
        logic [21:0] his[3] = '{22'h3FFFFF, 22'h000000, 22'h155555};
        logic [31:0] w;
        logic ovf, unf, inx;
        bit carried;
        string tag;

        #(PERIOD * 2 + 1);
        check("R13 reset word", out_word, 32'd0);
        check("R13 reset flags", flagvec(), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int m = 0; m < 4; m++)
            for (int ei = 0; ei < 7; ei++)
                for (int hi = 0; hi < 3; hi++)
                    for (int lsb = 0; lsb < 2; lsb++)
                        for (int grs = 0; grs < 8; grs++) begin
                            logic [25:0] sg;
                            logic [2:0] g3;
                            logic sgn;
                            g3 = grs[2:0];
                            sgn = (lsb == 1) ^ (m == 2);
                            sg = {1'b1, his[hi], lsb[0], g3[2:1]};
                            model(m, sgn, exps[ei], sg, g3[0], w, ovf, unf, inx, carried);
                            apply(m[1:0], sgn, exps[ei], sg, g3[0], 0, 0, 0, 1);
                            if (ovf) tag = (m == 1) ? "R6 clamp" : "R5 infinity";
                            else if (unf) tag = "R7 underflow";
                            else if (carried) tag = "R4 carry";
                            else if (m == 1) tag = "R3 truncate";
                            else if (m >= 2) tag = "R1 reserved mode";
                            else tag = "R2 nearest";
                            // sample already taken one cycle after drive
                            check(tag, out_word, w);
                            check("R8 flags", {29'd0, out_ovf, out_unf, out_inx},
                                  {29'd0, ovf, unf, inx});
                        end

        // zero significand with stray low bits
        apply(2'b00, 1'b1, 5, 26'h0000003, 1'b1, 0, 0, 0, 1);
        check("R9 zero word", out_word, 32'h80000000);
        check("R9 zero flags", flagvec(), 32'h20);

        // invalid forces NaN even when the value would overflow
        apply(2'b00, 1'b1, 200, 26'h3FFFFFF, 1'b1, 1, 0, 0, 1);
        check("R10 nan word", out_word, 32'h7FC00000);
        check("R10 nan flags", flagvec(), 32'h30);

        // divide-by-zero passes without touching the word
        apply(2'b00, 1'b0, 0, 26'h2000000, 1'b0, 0, 1, 0, 1);
        check("R11 dz word", out_word, 32'h3F800000);
        check("R11 dz flag", flagvec(), 32'h28);

        // denormal error gating
        apply(2'b00, 1'b0, 0, 26'h2000000, 1'b0, 0, 0, 1, 0);
        check("R12 err raised", flagvec(), 32'h60);
        apply(2'b00, 1'b0, 0, 26'h2000000, 1'b0, 0, 0, 1, 1);
        check("R12 err masked", flagvec(), 32'h20);

        // cycle after an idle input: quiet outputs
        @(posedge clk); #1;
        check("R13 idle word", out_word, 32'd0);
        check("R13 idle flags", flagvec(), 32'd0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule